// File: doc/BRIEF.md
# Dual-Role UTOPIA Cell Output Port

This block moves 53-byte ATM cells out of an internal one-cell store and onto a byte-wide UTOPIA bus. Cell bytes arrive from an internal producer over a valid/ready stream. A byte is accepted on any clock edge where both `src_valid_i` and `src_ready_o` are high. Every group of 53 accepted bytes forms one cell. `src_ready_o` falls once a full cell is held, so the producer is back-pressured until that cell has left on the bus. The producer may drop `src_valid_i` in any cycle without losing its place.

A static mode pin picks the role. In the ATM-layer role the block is a transmit master. It watches the PHY's cell-available line, pulls its own active-low enable low and sends the cell as 53 back-to-back bytes. In the PHY-layer role it is a receive-side slave. An ATM-layer device reads the cell by pulling a read enable low. In single-PHY sub-mode any sampled read enable counts. In multi-PHY sub-mode the reader must first select the port by address. In the PHY role the data and start-of-cell lines are released (output enable low) whenever no byte is being handed over. Tri-state pads are modelled as separate output-enable ports, and all signals are synchronous to the one UTOPIA clock.

Top module: `utopia_cell_tx`

## Requirements
- R1: `role_phy_i` = 0 selects the ATM-layer role and 1 selects the PHY-layer role. During and after reset, the ATM role drives data and start-of-cell to 0 with their enables high and holds `enb_n_o` high. The PHY role holds the data, start-of-cell and `enb_n_o` output enables low.
- R2: `bus_soc_o` is high exactly in the cycle where `bus_data_o` carries byte 0 of a cell. Bytes leave in the order they were accepted, and each keeps its bit positions (bit 7 MSB, bit 0 LSB).
- R3: `src_ready_o` is high while fewer than 53 bytes are held. It goes low on the edge that accepts the 53rd byte and stays low until the cell's last byte has been sent.
- R4: In the ATM role, `enb_n_o` falls only when a full cell is held and `clav_i` was sampled high on that edge. The cell then follows as 53 consecutive bytes, one per clock.
- R5: In the ATM role, `enb_n_o` returns high in the cycle after byte 52 when no further full cell is held, and data then returns to 0.
- R6: In single-PHY sub-mode, the data and start-of-cell output enables are high only in a cycle that follows an edge where `enb_n_i` was sampled low while a cell was held. They are low otherwise.
- R7: In the PHY role, if `enb_n_i` is raised in the middle of a cell, the byte position holds. The next sampled-low enable delivers the byte that would have come next.
- R8: In single-PHY sub-mode, `clav_o` is always enabled and is 1 exactly while a full cell is held. In multi-PHY sub-mode, `clav_oe_o` is high only in the cycle after an edge where `bus_addr_i` equalled `local_addr_i`.
- R9: In multi-PHY sub-mode, the port is selected when `bus_addr_i` matched `local_addr_i` on the edge just before `enb_n_i` goes from high to low. It drives only while selected, and the selection clears when the cell's last byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UTOPIA clock, up to 33 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_phy_i | input | 1 | Static role: 0 ATM-layer master, 1 PHY-layer slave |
| mphy_i | input | 1 | PHY role sub-mode: 0 single-PHY, 1 multi-PHY |
| local_addr_i | input | ADDR_W | This port's multi-PHY address |
| bus_addr_i | input | ADDR_W | Address driven by the ATM layer for polling and selection |
| src_valid_i | input | 1 | Producer byte valid |
| src_data_i | input | DATA_W | Producer cell byte |
| src_ready_o | output | 1 | Store can accept a byte |
| bus_data_o | output | DATA_W | UTOPIA data bus |
| bus_data_oe_o | output | 1 | Drive enable for bus_data_o |
| bus_soc_o | output | 1 | Start-of-cell, high on byte 0 |
| bus_soc_oe_o | output | 1 | Drive enable for bus_soc_o |
| enb_n_i | input | 1 | Active-low read enable from the ATM layer (PHY role) |
| enb_n_o | output | 1 | Active-low transmit enable toward the PHY (ATM role) |
| enb_n_oe_o | output | 1 | Drive enable for enb_n_o |
| clav_i | input | 1 | Cell-available from the PHY (ATM role) |
| clav_o | output | 1 | Cell-available toward the ATM layer (PHY role) |
| clav_oe_o | output | 1 | Drive enable for clav_o |

## Verification
Each role sends cells whose byte values start at different seeds, one of which wraps past 0xFF, so byte order, start-of-cell position and bit placement are all checked. In the PHY role, read-enable patterns that pause before byte 0, in the middle of a cell and just before the last byte separate a position counter that holds from one that skips or restarts. In multi-PHY sub-mode, three separate cases are tried: selection with a non-matching address, selection with the local address, and a read enable held low across the end of a cell. Together they tell selection latching apart from selection clearing. In the ATM role, holding cell-available low with a full cell checks that the transmit enable waits for the PHY rather than for the cell alone.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic {
    ROLE_ATM = 1'b0,
    ROLE_PHY = 1'b1
  } role_e;

  typedef enum logic {
    SUB_SINGLE = 1'b0,
    SUB_MULTI  = 1'b1
  } sub_e;
endpackage

// File: rtl/utx_cell_buf.sv
module utx_cell_buf #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  localparam int IDX_W     = $clog2(CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  input  logic              release_i
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [DATA_W-1:0] store [CELL_BYTES];
  logic [IDX_W-1:0]  wr_ptr_q;
  logic              full_q;
  logic              wr_fire;

  assign in_ready_o = !full_q;
  assign wr_fire    = in_valid_i && !full_q;
  assign full_o     = full_q;
  assign rd_data_o  = store[rd_idx_i];

  always_ff @(posedge clk) begin
    if (wr_fire) store[wr_ptr_q] <= in_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      full_q   <= 1'b0;
    end else if (release_i) begin
      wr_ptr_q <= '0;
      full_q   <= 1'b0;
    end else if (wr_fire) begin
      if (wr_ptr_q == LAST_IDX) begin
        wr_ptr_q <= '0;
        full_q   <= 1'b1;
      end else begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/utx_byte_pos.sv
module utx_byte_pos #(
  parameter int CELL_BYTES = 53,
  localparam int IDX_W     = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  output logic [IDX_W-1:0] pos_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (advance_i) begin
      pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    end
  end

  assign pos_o   = pos_q;
  assign first_o = (pos_q == '0);
  assign last_o  = (pos_q == LAST_POS);
endmodule

// File: rtl/utx_mphy_sel.sv
module utx_mphy_sel #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enb_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] local_i,
  input  logic              end_cell_i,
  output logic              sel_o,
  output logic              poll_hit_o
);
  logic en_prev_q;
  logic match_q;
  logic sel_q;
  logic open_edge;

  assign open_edge  = en_prev_q && !enb_n_i;
  assign sel_o      = open_edge ? match_q : sel_q;
  assign poll_hit_o = match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev_q <= 1'b1;
      match_q   <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      en_prev_q <= enb_n_i;
      match_q   <= (addr_i == local_i);
      if (end_cell_i)     sel_q <= 1'b0;
      else if (open_edge) sel_q <= match_q;
    end
  end
endmodule

// File: rtl/utopia_cell_tx.sv
module utopia_cell_tx
  import utx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_phy_i,
  input  logic              mphy_i,
  input  logic [ADDR_W-1:0] local_addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  output logic              bus_soc_o,
  output logic              bus_soc_oe_o,
  input  logic              enb_n_i,
  output logic              enb_n_o,
  output logic              enb_n_oe_o,
  input  logic              clav_i,
  output logic              clav_o,
  output logic              clav_oe_o
);
  localparam int IDX_W = $clog2(CELL_BYTES);

  role_e             role;
  sub_e              sub;
  logic              full;
  logic [IDX_W-1:0]  pos;
  logic              pos_first;
  logic              pos_last;
  logic [DATA_W-1:0] rd_byte;
  logic              sel;
  logic              poll_hit;
  logic              atm_adv;
  logic              phy_adv;
  logic              adv;
  logic              end_cell;
  logic              sending_q;
  logic              drv_q;
  logic              soc_q;
  logic              en_n_q;
  logic [DATA_W-1:0] data_q;

  assign role = role_e'(role_phy_i);
  assign sub  = sub_e'(mphy_i);

  utx_cell_buf #(
    .DATA_W    (DATA_W),
    .CELL_BYTES(CELL_BYTES)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid_i(src_valid_i),
    .in_data_i (src_data_i),
    .in_ready_o(src_ready_o),
    .rd_idx_i  (pos),
    .rd_data_o (rd_byte),
    .full_o    (full),
    .release_i (end_cell)
  );

  utx_byte_pos #(
    .CELL_BYTES(CELL_BYTES)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance_i(adv),
    .pos_o    (pos),
    .first_o  (pos_first),
    .last_o   (pos_last)
  );

  utx_mphy_sel #(
    .ADDR_W(ADDR_W)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .enb_n_i   (enb_n_i),
    .addr_i    (bus_addr_i),
    .local_i   (local_addr_i),
    .end_cell_i(end_cell),
    .sel_o     (sel),
    .poll_hit_o(poll_hit)
  );

  // ATM role: start on cell-available with a full cell, then run to the end
  assign atm_adv = full && (sending_q || clav_i);
  // PHY role: one byte per sampled-low read enable while a cell is held
  assign phy_adv = !enb_n_i && full && ((sub == SUB_MULTI) ? sel : 1'b1);

  always_comb begin
    unique case (role)
      ROLE_ATM: adv = atm_adv;
      ROLE_PHY: adv = phy_adv;
      default:  adv = 1'b0;
    endcase
  end

  assign end_cell = adv && pos_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending_q <= 1'b0;
      drv_q     <= 1'b0;
      soc_q     <= 1'b0;
      en_n_q    <= 1'b1;
      data_q    <= '0;
    end else begin
      sending_q <= (role == ROLE_ATM) && atm_adv && !pos_last;
      drv_q     <= adv;
      soc_q     <= adv && pos_first;
      en_n_q    <= !((role == ROLE_ATM) && adv);
      data_q    <= adv ? rd_byte : '0;
    end
  end

  assign bus_data_o    = data_q;
  assign bus_soc_o     = soc_q;
  assign bus_data_oe_o = (role == ROLE_ATM) || drv_q;
  assign bus_soc_oe_o  = (role == ROLE_ATM) || drv_q;
  assign enb_n_o       = en_n_q;
  assign enb_n_oe_o    = (role == ROLE_ATM);
  assign clav_o        = full;
  assign clav_oe_o     = (role == ROLE_PHY) && ((sub == SUB_SINGLE) || poll_hit);
endmodule

// File: rtl/utx_port_chk.sv
module utx_port_chk #(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int ADDR_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              role_phy_i,
  input logic              mphy_i,
  input logic [ADDR_W-1:0] local_addr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_data_oe_o,
  input logic              bus_soc_o,
  input logic              enb_n_i,
  input logic              enb_n_o,
  input logic              clav_i,
  input logic              clav_oe_o
);
  localparam int CW = $clog2(CELL_BYTES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(CELL_BYTES - 1);

  logic          xfer_now;
  logic [CW-1:0] byte_cnt;

  assign xfer_now = role_phy_i ? bus_data_oe_o : !enb_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_cnt <= '0;
    else if (xfer_now) byte_cnt <= (byte_cnt == LAST_CNT) ? '0 : byte_cnt + 1'b1;
  end

  AST_SOC_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_now |-> (bus_soc_o == (byte_cnt == '0))); // R2

  AST_ATM_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_phy_i && enb_n_o) |-> (bus_data_o == '0 && !bus_soc_o)); // R1

  AST_ATM_START_CLAV: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_phy_i && $fell(enb_n_o)) |-> ($past(clav_i) && bus_soc_o)); // R4

  AST_PHY_NO_ENB_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (role_phy_i && $past(enb_n_i)) |-> !bus_data_oe_o); // R6

  AST_MPHY_POLL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (role_phy_i && mphy_i && clav_oe_o) |-> $past(bus_addr_i == local_addr_i)); // R8
endmodule

bind utopia_cell_tx utx_port_chk #(
  .DATA_W    (DATA_W),
  .CELL_BYTES(CELL_BYTES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .role_phy_i   (role_phy_i),
  .mphy_i       (mphy_i),
  .local_addr_i (local_addr_i),
  .bus_addr_i   (bus_addr_i),
  .bus_data_o   (bus_data_o),
  .bus_data_oe_o(bus_data_oe_o),
  .bus_soc_o    (bus_soc_o),
  .enb_n_i      (enb_n_i),
  .enb_n_o      (enb_n_o),
  .clav_i       (clav_i),
  .clav_oe_o    (clav_oe_o)
);

// File: tb/utopia_cell_tx_tb.sv
module utopia_cell_tx_tb;
  localparam int CLK_PERIOD = 30;
  localparam int NB = 53;
  localparam logic [4:0] MY_ADDR = 5'd6;
  localparam logic [4:0] NULL_ADDR = 5'h1F;
  // {role, mphy, pause_at[5:0], pause_len[7:0], seed[7:0]}
  localparam logic [23:0] SCN [7] = '{
    {1'b0, 1'b0, 6'd63, 8'd0, 8'h10},
    {1'b0, 1'b0, 6'd63, 8'd0, 8'hF0},
    {1'b1, 1'b0, 6'd63, 8'd0, 8'h00},
    {1'b1, 1'b0, 6'd0,  8'd3, 8'h55},
    {1'b1, 1'b0, 6'd20, 8'd2, 8'hA0},
    {1'b1, 1'b1, 6'd52, 8'd3, 8'h33},
    {1'b1, 1'b1, 6'd63, 8'd0, 8'hC8}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       role_phy_i = 1'b0;
  logic       mphy_i = 1'b0;
  logic [4:0] local_addr_i = MY_ADDR;
  logic [4:0] bus_addr_i = NULL_ADDR;
  logic       src_valid_i = 1'b0;
  logic [7:0] src_data_i = '0;
  logic       src_ready_o;
  logic [7:0] bus_data_o;
  logic       bus_data_oe_o, bus_soc_o, bus_soc_oe_o;
  logic       enb_n_i = 1'b1;
  logic       enb_n_o, enb_n_oe_o;
  logic       clav_i = 1'b0;
  logic       clav_o, clav_oe_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utopia_cell_tx u_dut (
    .clk(clk), .rst_n(rst_n), .role_phy_i(role_phy_i), .mphy_i(mphy_i),
    .local_addr_i(local_addr_i), .bus_addr_i(bus_addr_i),
    .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_ready_o(src_ready_o),
    .bus_data_o(bus_data_o), .bus_data_oe_o(bus_data_oe_o),
    .bus_soc_o(bus_soc_o), .bus_soc_oe_o(bus_soc_oe_o),
    .enb_n_i(enb_n_i), .enb_n_o(enb_n_o), .enb_n_oe_o(enb_n_oe_o),
    .clav_i(clav_i), .clav_o(clav_o), .clav_oe_o(clav_oe_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit role, input bit mphy);
    rst_n = 1'b0;
    role_phy_i = role;
    mphy_i = mphy;
    enb_n_i = 1'b1;
    clav_i = 1'b0;
    src_valid_i = 1'b0;
    bus_addr_i = NULL_ADDR;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_cell(input logic [7:0] seed);
    @(negedge clk);
    chk(src_ready_o == 1'b1, "R3", src_ready_o, 1);
    src_valid_i = 1'b1;
    src_data_i = seed;
    for (int i = 1; i < NB; i++) begin
      @(negedge clk);
      src_data_i = 8'(seed + i);
    end
    @(negedge clk);
    src_valid_i = 1'b0;
    chk(src_ready_o == 1'b0, "R3", src_ready_o, 0);
  endtask

  task automatic run_atm(input logic [7:0] seed);
    clav_i = 1'b1;
    load_cell(seed);
    for (int w = 0; w < 6 && enb_n_o; w++) @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      chk(enb_n_o == 1'b0, "R4", enb_n_o, 0);
      chk(bus_data_o == 8'(seed + i), "R2", bus_data_o, 8'(seed + i));
      chk(bus_soc_o == (i == 0), "R2", bus_soc_o, (i == 0));
      @(negedge clk);
    end
    chk(enb_n_o == 1'b1, "R5", enb_n_o, 1);
    chk(bus_data_o == 8'h00, "R5", bus_data_o, 0);
    chk(src_ready_o == 1'b1, "R3", src_ready_o, 1);
    clav_i = 1'b0;
  endtask

  task automatic run_phy(input bit mphy, input int pause_at, input int pause_len,
                         input logic [7:0] seed, input bit hold_end);
    int  idx = 0;
    int  pcnt = 0;
    bit  prev_low = 1'b0;
    bit  en;
    bit  moved;
    string dreq;
    dreq = (pause_len > 0) ? "R7" : "R2";
    load_cell(seed);
    enb_n_i = 1'b1;
    bus_addr_i = MY_ADDR;
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      moved = 1'b0;
      if (prev_low && idx < NB) begin
        chk(bus_data_oe_o == 1'b1, mphy ? "R9" : "R6", bus_data_oe_o, 1);
        chk(bus_data_o == 8'(seed + idx), dreq, bus_data_o, 8'(seed + idx));
        chk(bus_soc_o == (idx == 0), "R2", bus_soc_o, (idx == 0));
        idx++;
        moved = 1'b1;
      end else begin
        chk(bus_data_oe_o == 1'b0, "R6", bus_data_oe_o, 0);
      end
      if (idx == NB && !moved) break;
      if (idx < NB && idx == pause_at && pcnt < pause_len) begin
        en = 1'b1;
        pcnt++;
      end else if (idx >= NB) begin
        en = !hold_end;
      end else begin
        en = 1'b0;
      end
      enb_n_i = en;
      bus_addr_i = (en && mphy) ? MY_ADDR : NULL_ADDR;
      if (!mphy) bus_addr_i = NULL_ADDR;
      prev_low = !en;
    end
    chk(idx == NB, "R7", idx, NB);
    if (!mphy) chk(clav_o == 1'b0 && clav_oe_o == 1'b1, "R8", clav_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // Table walk: every role and sub-mode with its enable pattern
    for (int s = 0; s < 7; s++) begin
      do_reset(SCN[s][23], SCN[s][22]);
      if (!SCN[s][23]) run_atm(SCN[s][7:0]);
      else run_phy(SCN[s][22], int'(SCN[s][21:16]), int'(SCN[s][15:8]), SCN[s][7:0], 1'b0);
    end

    // R1: reset values in each role
    rst_n = 1'b0; role_phy_i = 1'b0; mphy_i = 1'b0;
    @(negedge clk);
    chk(bus_data_oe_o && bus_soc_oe_o && bus_data_o == 0 && !bus_soc_o, "R1", bus_data_o, 0);
    chk(enb_n_o == 1'b1 && enb_n_oe_o == 1'b1, "R1", enb_n_o, 1);
    role_phy_i = 1'b1;
    @(negedge clk);
    chk(!bus_data_oe_o && !bus_soc_oe_o && !enb_n_oe_o, "R1", bus_data_oe_o, 0);

    // R4: full cell but PHY not ready, transmit enable must wait
    do_reset(1'b0, 1'b0);
    load_cell(8'h77);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(enb_n_o == 1'b1, "R4", enb_n_o, 1);
    end
    clav_i = 1'b1;
    @(negedge clk);
    chk(enb_n_o == 1'b0 && bus_soc_o && bus_data_o == 8'h77, "R4", bus_data_o, 8'h77);
    clav_i = 1'b0;

    // R8: single-PHY cell-available follows the store
    do_reset(1'b1, 1'b0);
    @(negedge clk);
    chk(clav_oe_o == 1'b1 && clav_o == 1'b0, "R8", clav_o, 0);
    load_cell(8'h01);
    chk(clav_o == 1'b1, "R8", clav_o, 1);

    // R8/R9: multi-PHY polling and a non-matching selection
    do_reset(1'b1, 1'b1);
    load_cell(8'h90);
    bus_addr_i = MY_ADDR;
    @(negedge clk);
    chk(clav_oe_o == 1'b1 && clav_o == 1'b1, "R8", clav_oe_o, 1);
    bus_addr_i = 5'd3;
    @(negedge clk);
    chk(clav_oe_o == 1'b0, "R8", clav_oe_o, 0);
    enb_n_i = 1'b0;
    bus_addr_i = NULL_ADDR;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(bus_data_oe_o == 1'b0, "R9", bus_data_oe_o, 0);
    end
    enb_n_i = 1'b1;

    // R9: selection clears at cell end even with enable held low
    do_reset(1'b1, 1'b1);
    run_phy(1'b1, 63, 0, 8'h20, 1'b1);
    load_cell(8'h40);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(bus_data_oe_o == 1'b0, "R9", bus_data_oe_o, 0);
    end
    enb_n_i = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule